// File: doc/BRIEF.md
# Serial NOR Flash Command Responder

This block is the target side of a serial NOR flash on a mode-0 SPI bus (clock idle low, data sampled on the rising edge, changed on the falling edge). It takes an opcode byte after chip select falls. Depending on the opcode it then collects address or payload bytes, streams response bytes on MISO, or updates its mode state. The mode state consists of a write-enable latch, a wide (4-byte) address flag, an 8-bit bank register and a soft-reset arming latch. The serial inputs are sampled by the block clock `clk`, so SCK must run at least four times slower than `clk`.

With the wide flag clear, a command carries a 24-bit address. The low two bits of the bank register then supply address bits 25:24, which is the same as adding bank times 16 MiB. With the wide flag set, the command carries a full 32-bit address, most significant byte first. Storage is modelled as one small window of `2**WIN_AW` bytes in each of the four 16 MiB banks. The array index is {address[25:24], address[WIN_AW-1:0]}, so a bank change is visible in the data returned.

Raising chip select always ends the current command and returns the block to waiting for an opcode. All mode state survives this.

Top module: `spinor_flash`

## Requirements
- R1: After `rst`, the wide flag, the write-enable latch, the arming latch and the bank register are all clear. Bank read (0xC8) returns 0x00, and a page program sent without a preceding 0x06 changes nothing.
- R2: Opcode 0x9F returns 0x20, 0xBA, 0x19 in the three byte slots after the opcode, and returns 0x00 after that.
- R3: Opcode 0x70 returns 0x80 (bit 7 = ready) in every byte slot until chip select rises.
- R4: Opcode 0x06 sets the write-enable latch. Opcode 0x02 with the latch set writes each byte that follows the address to consecutive addresses. Without the latch set, 0x02 is ignored. Raising chip select after an accepted 0x02 clears the latch.
- R5: Opcode 0x03 returns the byte at the collected address in the slot after the last address byte, then the following addresses. The low WIN_AW address bits wrap inside the window of the current bank.
- R6: Opcode 0x0B behaves like 0x03, except that one dummy slot returning 0x00 comes before the data.
- R7: Opcode 0xB7 sets the wide flag and 0xE9 clears it. While the flag is set, read and program commands take four address bytes, most significant first, and bits 25:24 come from the address itself.
- R8: While the wide flag is clear, the effective address is the 24-bit address plus (bank register bits 1:0) × 0x1000000.
- R9: Opcode 0xC5 loads the bank register from the next byte, but only while the write-enable latch is set. Otherwise it is ignored. Opcode 0xC8 returns the bank register in every following slot.
- R10: Opcode 0x99 does nothing unless 0x66 armed it beforehand. An armed 0x99 clears the write-enable latch, the wide flag, the bank register, the arming latch and the current address.
- R11: Raising chip select part way through a command abandons it. The next byte after chip select falls again is decoded as an opcode, and the mode state is unchanged, apart from the write-enable clear described in R4.
- R12: An unknown opcode makes the block ignore every further byte until chip select rises. MISO returns 0x00 and no state changes.
- R13: The response byte for a slot is loaded on the SCK falling edge that ends the previous slot, most significant bit first. MISO is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
A byte is complete two `clk` cycles after the sampled eighth rising SCK edge: one cycle for edge detection and one for the engine update. The response for the next slot is loaded at the following falling edge and is visible one `clk` later. The bench holds each SCK level for four `clk` cycles and reads each MISO bit just before it raises SCK, so every response bit is sampled at least three cycles after it settles. Mode changes are checked only in a later command, opened by a fresh chip select. This matches the block applying a decoded opcode one cycle after its last bit.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

    localparam int BYTE_W   = 8;
    localparam int BIT_CW   = $clog2(BYTE_W);
    localparam int BANK_W   = 2;
    localparam int ADDR_W   = 32;
    localparam int NARROW_W = 24;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_PROG  = 8'h02;
    localparam byte_t OP_READ  = 8'h03;
    localparam byte_t OP_WREN  = 8'h06;
    localparam byte_t OP_FREAD = 8'h0B;
    localparam byte_t OP_RSTEN = 8'h66;
    localparam byte_t OP_FLAG  = 8'h70;
    localparam byte_t OP_RST   = 8'h99;
    localparam byte_t OP_ID    = 8'h9F;
    localparam byte_t OP_WIDE  = 8'hB7;
    localparam byte_t OP_BANKW = 8'hC5;
    localparam byte_t OP_BANKR = 8'hC8;
    localparam byte_t OP_NARW  = 8'hE9;

    localparam byte_t FLAG_READY = 8'h80;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_DUMMY, ST_READ, ST_PROG,
        ST_BANKW, ST_FLAG, ST_BANKR, ST_ID, ST_SKIP
    } cmd_state_e;

    typedef struct packed {
        logic  wel;
        logic  wide;
        byte_t bank;
        logic  rst_arm;
    } mode_t;

    function automatic logic [ADDR_W-1:0] resolve_addr(
        input logic [ADDR_W-1:0] acc,
        input logic              wide,
        input byte_t             bank
    );
        if (wide)
            return acc;
        return {{(ADDR_W-NARROW_W-BANK_W){1'b0}}, bank[BANK_W-1:0], acc[NARROW_W-1:0]};
    endfunction

endpackage

// File: rtl/spinor_shifter.sv
module spinor_shifter
    import spinor_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  sck,
    input  logic  mosi,
    input  byte_t tx_byte,
    output logic  byte_done,
    output byte_t rx_byte,
    output logic  miso
);

    logic              sck_q;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    byte_t             tx_sh;

    wire sck_rise = !cs_n &&  sck && !sck_q;
    wire sck_fall = !cs_n && !sck &&  sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            sck_q     <= sck;
            byte_done <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[BYTE_W-3:0], mosi};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BIT_CW'(BYTE_W-1)) begin
                        rx_byte   <= {rx_sh, mosi};
                        byte_done <= 1'b1;
                    end
                end
                if (sck_fall) begin
                    if (bit_cnt == '0)
                        tx_sh <= tx_byte;
                    else
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = !cs_n && tx_sh[BYTE_W-1];

endmodule

// File: rtl/spinor_store.sv
module spinor_store
    import spinor_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  byte_t            wdata,
    output byte_t            rdata
);

    localparam int DEPTH = 1 << IDX_W;

    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[idx] <= wdata;
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/spinor_engine.sv
module spinor_engine
    import spinor_pkg::*;
#(
    parameter int          WIN_AW = 6,
    parameter logic [23:0] DEV_ID = 24'h20BA19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             byte_done,
    input  byte_t            rx_byte,
    output byte_t            tx_byte,
    output logic             mem_we,
    output logic [WIN_AW+BANK_W-1:0] mem_idx,
    output byte_t            mem_wdata,
    input  byte_t            mem_rdata,
    output cmd_state_e       state_o,
    output mode_t            mode_o
);

    localparam int ACC_W = ADDR_W - BYTE_W;

    cmd_state_e         state;
    mode_t              mode;
    byte_t              op;
    logic [2:0]         addr_left;
    logic [ACC_W-1:0]   acc;
    logic [ADDR_W-1:0]  cur_addr;
    logic [1:0]         id_idx;
    logic [ADDR_W-1:0]  acc_full;

    assign acc_full = {acc, rx_byte};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode      <= '0;
            op        <= '0;
            addr_left <= '0;
            acc       <= '0;
            cur_addr  <= '0;
            id_idx    <= '0;
        end else if (cs_n) begin
            state <= ST_IDLE;
            if (state == ST_PROG)
                mode.wel <= 1'b0;
        end else if (byte_done) begin
            case (state)
                ST_IDLE: begin
                    op    <= rx_byte;
                    acc   <= '0;
                    state <= ST_SKIP;
                    case (rx_byte)
                        OP_READ, OP_FREAD: begin
                            addr_left <= mode.wide ? 3'd4 : 3'd3;
                            state     <= ST_ADDR;
                        end
                        OP_PROG: if (mode.wel) begin
                            addr_left <= mode.wide ? 3'd4 : 3'd3;
                            state     <= ST_ADDR;
                        end
                        OP_WREN:  mode.wel     <= 1'b1;
                        OP_WIDE:  mode.wide    <= 1'b1;
                        OP_NARW:  mode.wide    <= 1'b0;
                        OP_RSTEN: mode.rst_arm <= 1'b1;
                        OP_RST: if (mode.rst_arm) begin
                            mode     <= '0;
                            cur_addr <= '0;
                        end
                        OP_BANKW: if (mode.wel) state <= ST_BANKW;
                        OP_BANKR: state <= ST_BANKR;
                        OP_FLAG:  state <= ST_FLAG;
                        OP_ID: begin
                            id_idx <= '0;
                            state  <= ST_ID;
                        end
                        default: ;
                    endcase
                end
                ST_ADDR: begin
                    acc       <= acc_full[ACC_W-1:0];
                    addr_left <= addr_left - 1'b1;
                    if (addr_left == 3'd1) begin
                        cur_addr <= resolve_addr(acc_full, mode.wide, mode.bank);
                        if (op == OP_FREAD)
                            state <= ST_DUMMY;
                        else if (op == OP_PROG)
                            state <= ST_PROG;
                        else
                            state <= ST_READ;
                    end
                end
                ST_DUMMY: state    <= ST_READ;
                ST_READ:  cur_addr <= cur_addr + 1'b1;
                ST_PROG:  cur_addr <= cur_addr + 1'b1;
                ST_BANKW: begin
                    mode.bank <= rx_byte;
                    state     <= ST_SKIP;
                end
                ST_ID: if (id_idx != 2'd3) id_idx <= id_idx + 1'b1;
                default: ;
            endcase
        end
    end

    assign mem_idx   = {cur_addr[NARROW_W +: BANK_W], cur_addr[WIN_AW-1:0]};
    assign mem_we    = byte_done && !cs_n && (state == ST_PROG);
    assign mem_wdata = rx_byte;

    always_comb begin
        case (state)
            ST_READ:  tx_byte = mem_rdata;
            ST_FLAG:  tx_byte = FLAG_READY;
            ST_BANKR: tx_byte = mode.bank;
            ST_ID: begin
                case (id_idx)
                    2'd0:    tx_byte = DEV_ID[23:16];
                    2'd1:    tx_byte = DEV_ID[15:8];
                    2'd2:    tx_byte = DEV_ID[7:0];
                    default: tx_byte = '0;
                endcase
            end
            default:  tx_byte = '0;
        endcase
    end

    assign state_o = state;
    assign mode_o  = mode;

endmodule

// File: rtl/spinor_flash.sv
module spinor_flash
    import spinor_pkg::*;
#(
    parameter int          WIN_AW = 6,
    parameter logic [23:0] DEV_ID = 24'h20BA19
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);

    localparam int IDX_W = WIN_AW + BANK_W;

    byte_t            tx_byte;
    byte_t            rx_byte;
    logic             byte_done;
    logic             mem_we;
    logic [IDX_W-1:0] mem_idx;
    byte_t            mem_wdata;
    byte_t            mem_rdata;
    cmd_state_e       eng_state;
    mode_t            eng_mode;

    spinor_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sck       (sck),
        .mosi      (mosi),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    spinor_engine #(.WIN_AW(WIN_AW), .DEV_ID(DEV_ID)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .state_o   (eng_state),
        .mode_o    (eng_mode)
    );

    spinor_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/spinor_flash_chk.sv
module spinor_flash_chk
    import spinor_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       byte_done,
    input byte_t      rx_byte,
    input cmd_state_e state,
    input mode_t      mode
);

    wire opcode_in = byte_done && !cs_n && (state == ST_IDLE);

    a_r10_unarmed_rst_noop: assert property (@(posedge clk) disable iff (rst)
        (opcode_in && rx_byte == OP_RST && !mode.rst_arm) |=> (mode == $past(mode)));

    a_r10_armed_rst_clears: assert property (@(posedge clk) disable iff (rst)
        (opcode_in && rx_byte == OP_RST && mode.rst_arm) |=> (mode == '0));

    a_r9_bank_write_guard: assert property (@(posedge clk) disable iff (rst)
        (opcode_in && rx_byte == OP_BANKW && !mode.wel) |=> (state != ST_BANKW));

    a_r11_cs_abort: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (state == ST_IDLE));

    a_r11_cs_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (cs_n && state != ST_PROG) |=> (mode == $past(mode)));

    a_r4_prog_end_clears_wel: assert property (@(posedge clk) disable iff (rst)
        (cs_n && state == ST_PROG) |=> !mode.wel);

    a_r13_single_byte_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !byte_done);

endmodule

bind spinor_flash spinor_flash_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .state     (eng_state),
    .mode      (eng_mode)
);

// File: tb/test_spinor_flash.sv
module test_spinor_flash;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int WIN_AW     = 6;
    localparam int WIN        = 1 << WIN_AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_mem [4*WIN];

    always #(CLK_PERIOD/2) clk = ~clk;

    spinor_flash #(.WIN_AW(WIN_AW)) i_spinor_flash (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        tick(HALF_SCK);
    endtask

    task automatic cs_end();
        tick(HALF_SCK);
        cs_n = 1'b1;
        tick(2*HALF_SCK);
    endtask

    task automatic xfer(input logic [7:0] din, output logic [7:0] dout);
        for (int b = 7; b >= 0; b--) begin
            mosi = din[b];
            tick(HALF_SCK);
            dout[b] = miso;
            sck = 1'b1;
            tick(HALF_SCK);
            sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_begin();
        xfer(op, d);
        cs_end();
    endtask

    task automatic send_addr(input logic [31:0] a, input bit wide);
        logic [7:0] d;
        for (int k = (wide ? 3 : 2); k >= 0; k--)
            xfer(a[8*k +: 8], d);
    endtask

    function automatic int bank_of(input logic [31:0] a, input bit wide, input logic [7:0] bank);
        return wide ? int'(a[25:24]) : int'(bank[1:0]);
    endfunction

    // Reads n bytes, checking each against the model; offsets wrap inside the window.
    task automatic rd_check(input logic [7:0] op, input logic [31:0] a, input bit wide,
                            input logic [7:0] bank, input int n, input string tag);
        logic [7:0] d;
        int bk, off;
        bk  = bank_of(a, wide, bank);
        off = int'(a) % WIN;
        cs_begin();
        xfer(op, d);
        send_addr(a, wide);
        if (op == 8'h0B) begin
            xfer(8'h00, d);
            chk(d, 8'h00, {tag, " dummy slot R6"});
        end
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, d);
            chk(d, exp_mem[bk*WIN + (off + i) % WIN], tag);
        end
        cs_end();
    endtask

    task automatic prog(input logic [31:0] a, input bit wide, input logic [7:0] bank,
                        input int n, input int seed, input bit accepted);
        logic [7:0] d;
        int bk, off;
        bk  = bank_of(a, wide, bank);
        off = int'(a) % WIN;
        cs_begin();
        xfer(8'h02, d);
        send_addr(a, wide);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'((i*37 + seed*11 + 5) & 255);
            xfer(v, d);
            if (accepted)
                exp_mem[bk*WIN + (off + i) % WIN] = v;
        end
        cs_end();
    endtask

    task automatic stream_check(input logic [7:0] op, input int n, input logic [7:0] e0,
                                input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] rest,
                                input string tag);
        logic [7:0] d;
        cs_begin();
        xfer(op, d);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, d);
            chk(d, (i == 0) ? e0 : (i == 1) ? e1 : (i == 2) ? e2 : rest, tag);
        end
        cs_end();
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] ear;
        ear = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(2);

        // reset state
        chk({7'd0, miso}, 8'h00, "R13 miso low while deselected");
        stream_check(8'hC8, 2, 8'h00, 8'h00, 8'h00, 8'h00, "R1 bank reads zero after reset");
        stream_check(8'h70, 5, 8'h80, 8'h80, 8'h80, 8'h80, "R3 flag byte repeats");
        stream_check(8'h9F, 5, 8'h20, 8'hBA, 8'h19, 8'h00, "R2 R13 id bytes");

        // write-enable gating
        prog(32'h10, 1'b0, ear, 1, 7, 1'b0);
        cmd1(8'h06);
        prog(32'h10, 1'b0, ear, 1, 1, 1'b1);
        rd_check(8'h03, 32'h10, 1'b0, ear, 1, "R4 accepted program");
        prog(32'h10, 1'b0, ear, 1, 9, 1'b0);
        rd_check(8'h03, 32'h10, 1'b0, ear, 1, "R4 wel cleared after program");

        // full sweep of each bank through the bank register
        for (int b = 0; b < 4; b++) begin
            if (b > 0) begin
                cmd1(8'h06);
                cs_begin(); xfer(8'hC5, d); xfer(8'(b), d); cs_end();
                ear = 8'(b);
            end
            stream_check(8'hC8, 2, ear, ear, ear, ear, "R9 bank register readback");
            cmd1(8'h06);
            prog({8'h00, 8'(b*16 + 3), 16'h0000}, 1'b0, ear, WIN, 20 + b, 1'b1);
            rd_check(8'h03, {8'h00, 8'(b*16 + 1), 8'h00, 8'(WIN - 4)}, 1'b0, ear, WIN + 8,
                     "R5 R8 read wraps within bank window");
        end
        rd_check(8'h0B, 32'h0000_0005, 1'b0, ear, 10, "R6 fast read data");

        // bank write without write enable
        cs_begin(); xfer(8'hC5, d); xfer(8'h01, d); cs_end();
        stream_check(8'hC8, 1, 8'h03, 8'h03, 8'h03, 8'h03, "R9 bank write ignored without wel");

        // wide addressing
        cmd1(8'hB7);
        rd_check(8'h03, 32'h0100_0007, 1'b1, ear, 4, "R7 wide read selects bank from address");
        rd_check(8'h0B, 32'h0200_003F, 1'b1, ear, 3, "R7 wide fast read");
        cmd1(8'h06);
        prog(32'h0000_0020, 1'b1, ear, 2, 40, 1'b1);
        rd_check(8'h03, 32'h0000_0020, 1'b1, ear, 2, "R7 wide program");
        cmd1(8'hE9);
        rd_check(8'h03, 32'h0000_0007, 1'b0, ear, 2, "R7 R8 narrow again uses bank register");

        // soft reset
        cmd1(8'hB7);
        cmd1(8'h99);
        stream_check(8'hC8, 1, 8'h03, 8'h03, 8'h03, 8'h03, "R10 unarmed reset keeps bank");
        rd_check(8'h03, 32'h0100_0008, 1'b1, ear, 2, "R10 unarmed reset keeps wide mode");
        cmd1(8'h06);
        cmd1(8'h66);
        cmd1(8'h99);
        ear = 8'h00;
        stream_check(8'hC8, 1, 8'h00, 8'h00, 8'h00, 8'h00, "R10 armed reset clears bank");
        rd_check(8'h03, 32'h0000_0009, 1'b0, ear, 2, "R10 armed reset clears wide mode");
        prog(32'h11, 1'b0, ear, 1, 50, 1'b0);
        rd_check(8'h03, 32'h11, 1'b0, ear, 1, "R10 armed reset clears wel");
        cmd1(8'h99);
        stream_check(8'hC8, 1, 8'h00, 8'h00, 8'h00, 8'h00, "R10 arming consumed");

        // chip select abort
        cmd1(8'h06);
        cs_begin(); xfer(8'hC5, d); cs_end();
        stream_check(8'hC8, 1, 8'h00, 8'h00, 8'h00, 8'h00, "R11 aborted bank write");
        prog(32'h12, 1'b0, ear, 1, 60, 1'b1);
        rd_check(8'h03, 32'h12, 1'b0, ear, 1, "R11 wel kept across abort");
        cs_begin(); xfer(8'h03, d); xfer(8'h00, d); cs_end();
        stream_check(8'h70, 2, 8'h80, 8'h80, 8'h80, 8'h80, "R11 fresh opcode after abort");

        // unknown opcode
        stream_check(8'h5A, 3, 8'h00, 8'h00, 8'h00, 8'h00, "R12 unknown opcode silent");
        cs_begin(); xfer(8'h5A, d); xfer(8'h06, d); xfer(8'h9F, d);
        chk(d, 8'h00, "R12 bytes after unknown opcode ignored");
        cs_end();
        prog(32'h13, 1'b0, ear, 1, 70, 1'b0);
        rd_check(8'h03, 32'h13, 1'b0, ear, 1, "R12 no wel from ignored bytes");

        chk({7'd0, miso}, 8'h00, "R13 miso low after deselect");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule